// File: doc/BRIEF.md
# SDRAM Burst Read Sequencer

This block runs read bus cycles against a 64-bit synchronous DRAM whose mode register is fixed at a burst length of four. One request takes an address and a type flag. A line fill returns all four 64-bit words of the 32-byte aligned block. It starts with the word that holds the requested address and then wraps around inside the block. A single read serves uncached or DMA traffic. It keeps only the first data cycle of the burst, and the three data cycles after it run idle. The memory still drives those cycles, so the bus stays reserved until the burst and the precharge time have both ended.

Every access follows the same sequence. The block issues an ACTIVE command with the row and waits tRCD cycles. It then issues a READ with auto-precharge, with the word column on the low address bits. After the CAS latency come four data cycles. A bus-start strobe marks the first of these data cycles. Each word the block keeps comes out one cycle after its data cycle, with a valid pulse and its word index.

The state machine has seven states:
- IDLE: ready for a request. Leaves on handshake, to ACT.
- ACT: one cycle. Goes to RCDW, or to RD when tRCD is 1.
- RCDW: tRCD-1 cycles, then RD.
- RD: one cycle, then CLW.
- CLW: CAS_LAT-1 cycles, then DATA.
- DATA: four cycles, then RECOV.
- RECOV: tRP cycles, then back to IDLE.

Top module: `sdram_burst_rd`

## Requirements
- R1: During and after reset, `req_ready` is 1 and the command pins carry NOP (`{cs_n,ras_n,cas_n,we_n}` = 0111). `bus_start`, `beat_valid` and `beat_last` are 0.
- R2: A request is accepted when `req_valid` and `req_ready` are both 1 at a clock edge. ACTIVE (0011) follows in the next cycle, with the row `req_addr[ADDR_W-1:COL_W+3]` on `sd_addr`. `req_ready` is 0 from that cycle until the access completes, and no request is accepted while it is 0.
- R3: READ (0101) comes exactly T_RCD cycles after ACTIVE. Its `sd_addr[COL_W-1:0]` equals `req_addr[COL_W+2:3]`, so the low two bits hold the start word `req_addr[4:3]`. `sd_addr[10]` is 1, which requests auto-precharge.
- R4: `bus_start` is high for exactly one cycle per access, CAS_LAT cycles after READ, which is the first data cycle. It is low in the other three data cycles.
- R5: A line fill (`req_fill`=1) yields four `beat_valid` pulses. Pulse i comes one cycle after data cycle i, carries the `sd_dq_in` value sampled in that data cycle, and has `beat_idx` = (start + i) mod 4.
- R6: `beat_last` is 1 only together with the fourth beat of a line fill.
- R7: A single read (`req_fill`=0) yields exactly one `beat_valid` pulse, one cycle after the first data cycle. It carries the data of that cycle only, with `beat_idx` = start and `beat_last` = 0. Data in the later three data cycles is discarded.
- R8: For both request types, `req_ready` returns to 1 exactly CAS_LAT+4+T_RP cycles after READ. The next ACTIVE therefore comes no earlier than that many cycles after the previous READ.
- R9: Each access issues exactly one ACTIVE and one READ, and no other command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can take a request |
| req_fill | input | 1 | 1 = line fill, 0 = single read |
| req_addr | input | ADDR_W | Byte address: row, word column, byte offset |
| sd_cs_n | output | 1 | SDRAM chip select |
| sd_ras_n | output | 1 | SDRAM row strobe |
| sd_cas_n | output | 1 | SDRAM column strobe |
| sd_we_n | output | 1 | SDRAM write enable |
| sd_addr | output | ROW_W | Row on ACTIVE; column and auto-precharge bit on READ |
| sd_dq_in | input | DATA_W | Read data from the SDRAM |
| bus_start | output | 1 | High in the first data cycle of each access |
| beat_valid | output | 1 | Returned word is valid |
| beat_idx | output | 2 | Word index within the 32-byte block |
| beat_last | output | 1 | Final word of a line fill |
| beat_data | output | DATA_W | Returned word |

## Verification
The hardest case to reach is a single read whose discarded trailing data cycles carry real, distinct words. A second request then waits with `req_valid` held high through the whole burst. The bench models the memory burst with wraparound and drives a different word in every data cycle, so latching any trailing cycle shows up as wrong data. It also holds `req_valid` high across a fill followed by a single read. This shows that nothing is accepted early and that the next ACTIVE respects the burst and the precharge time. All four start offsets are covered for both request types, including a fill that wraps at the top of a column range.

// File: rtl/sdram_rd_pkg.sv
package sdram_rd_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ACT,
        S_RCDW,
        S_RD,
        S_CLW,
        S_DATA,
        S_RECOV
    } rd_state_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sd_cmd_t;

    localparam sd_cmd_t CMD_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam sd_cmd_t CMD_ACT = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b1};
    localparam sd_cmd_t CMD_RD  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b1};

    localparam int BURST_LEN = 4;

endpackage

// File: rtl/sdram_rd_fsm.sv
module sdram_rd_fsm
    import sdram_rd_pkg::*;
#(
    parameter int T_RCD   = 2,
    parameter int CAS_LAT = 2,
    parameter int T_RP    = 2,
    parameter int CW      = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    output rd_state_e     state,
    output logic [CW-1:0] cnt
);

    rd_state_e     nxt;
    rd_state_e     after_act;
    logic [CW-1:0] cnt_nxt;

    generate
        if (T_RCD > 1) begin : g_rcd_wait
            assign after_act = S_RCDW;
        end else begin : g_rcd_none
            assign after_act = S_RD;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        nxt     = state;
        cnt_nxt = cnt + 1'b1;
        unique case (state)
            S_IDLE: begin
                cnt_nxt = '0;
                if (req_valid) nxt = S_ACT;
            end
            S_ACT: begin
                cnt_nxt = '0;
                nxt     = after_act;
            end
            S_RCDW: begin
                if (cnt == CW'(T_RCD - 2)) begin
                    nxt     = S_RD;
                    cnt_nxt = '0;
                end
            end
            S_RD: begin
                cnt_nxt = '0;
                nxt     = S_CLW;
            end
            S_CLW: begin
                if (cnt == CW'(CAS_LAT - 2)) begin
                    nxt     = S_DATA;
                    cnt_nxt = '0;
                end
            end
            S_DATA: begin
                if (cnt == CW'(BURST_LEN - 1)) begin
                    nxt     = S_RECOV;
                    cnt_nxt = '0;
                end
            end
            S_RECOV: begin
                if (cnt == CW'(T_RP - 1)) begin
                    nxt     = S_IDLE;
                    cnt_nxt = '0;
                end
            end
            default: begin
                nxt     = S_IDLE;
                cnt_nxt = '0;
            end
        endcase
    end

    assign req_ready = (state == S_IDLE);

endmodule

// File: rtl/sdram_rd_cmd.sv
module sdram_rd_cmd
    import sdram_rd_pkg::*;
#(
    parameter int ROW_W  = 12,
    parameter int COL_W  = 8,
    parameter int CW     = 4,
    parameter int AP_BIT = 10
) (
    input  rd_state_e        state,
    input  logic [CW-1:0]    cnt,
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    output logic             sd_cs_n,
    output logic             sd_ras_n,
    output logic             sd_cas_n,
    output logic             sd_we_n,
    output logic [ROW_W-1:0] sd_addr,
    output logic             bus_start
);

    sd_cmd_t cmd;

    always_comb begin
        cmd       = CMD_NOP;
        sd_addr   = '0;
        bus_start = 1'b0;
        unique case (state)
            S_ACT: begin
                cmd     = CMD_ACT;
                sd_addr = row;
            end
            S_RD: begin
                cmd             = CMD_RD;
                sd_addr         = ROW_W'(col);
                sd_addr[AP_BIT] = 1'b1;
            end
            S_DATA: begin
                bus_start = (cnt == '0);
            end
            default: begin
            end
        endcase
    end

    assign sd_cs_n  = cmd.cs_n;
    assign sd_ras_n = cmd.ras_n;
    assign sd_cas_n = cmd.cas_n;
    assign sd_we_n  = cmd.we_n;

endmodule

// File: rtl/sdram_rd_beat.sv
module sdram_rd_beat #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_cyc,
    input  logic [1:0]        pos,
    input  logic              fill,
    input  logic [1:0]        start,
    input  logic [DATA_W-1:0] dq,
    output logic              beat_valid,
    output logic [1:0]        beat_idx,
    output logic              beat_last,
    output logic [DATA_W-1:0] beat_data
);

    logic keep;

    assign keep = data_cyc && (fill || pos == 2'd0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_valid <= 1'b0;
            beat_idx   <= '0;
            beat_last  <= 1'b0;
            beat_data  <= '0;
        end else begin
            beat_valid <= keep;
            beat_last  <= keep && fill && (pos == 2'd3);
            if (keep) begin
                beat_idx  <= fill ? (start + pos) : start;
                beat_data <= dq;
            end
        end
    end

endmodule

// File: rtl/sdram_burst_rd.sv
module sdram_burst_rd
    import sdram_rd_pkg::*;
#(
    parameter int ROW_W   = 12,
    parameter int COL_W   = 8,
    parameter int DATA_W  = 64,
    parameter int T_RCD   = 2,
    parameter int CAS_LAT = 2,
    parameter int T_RP    = 2,
    localparam int ADDR_W = ROW_W + COL_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_fill,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ROW_W-1:0]  sd_addr,
    input  logic [DATA_W-1:0] sd_dq_in,
    output logic              bus_start,
    output logic              beat_valid,
    output logic [1:0]        beat_idx,
    output logic              beat_last,
    output logic [DATA_W-1:0] beat_data
);

    localparam int CW     = $clog2(T_RCD + CAS_LAT + T_RP + BURST_LEN) + 1;
    localparam int AP_BIT = 10;

    rd_state_e        state;
    logic [CW-1:0]    cnt;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic             fill_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q  <= '0;
            col_q  <= '0;
            fill_q <= 1'b0;
        end else if (req_valid && req_ready) begin
            row_q  <= req_addr[ADDR_W-1 -: ROW_W];
            col_q  <= req_addr[COL_W+2:3];
            fill_q <= req_fill;
        end
    end

    sdram_rd_fsm #(
        .T_RCD(T_RCD), .CAS_LAT(CAS_LAT), .T_RP(T_RP), .CW(CW)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_ready(req_ready), .state(state), .cnt(cnt)
    );

    sdram_rd_cmd #(
        .ROW_W(ROW_W), .COL_W(COL_W), .CW(CW), .AP_BIT(AP_BIT)
    ) u_cmd (
        .state(state), .cnt(cnt), .row(row_q), .col(col_q),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_addr(sd_addr), .bus_start(bus_start)
    );

    sdram_rd_beat #(
        .DATA_W(DATA_W)
    ) u_beat (
        .clk(clk), .rst_n(rst_n), .data_cyc(state == S_DATA),
        .pos(cnt[1:0]), .fill(fill_q), .start(col_q[1:0]), .dq(sd_dq_in),
        .beat_valid(beat_valid), .beat_idx(beat_idx),
        .beat_last(beat_last), .beat_data(beat_data)
    );

endmodule

// File: rtl/sdram_rd_chk.sv
module sdram_rd_chk #(
    parameter int ROW_W  = 12,
    parameter int AP_BIT = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             sd_cs_n,
    input logic             sd_ras_n,
    input logic             sd_cas_n,
    input logic             sd_we_n,
    input logic [ROW_W-1:0] sd_addr,
    input logic             bus_start,
    input logic             beat_valid,
    input logic             beat_last
);

    logic [3:0] cmd;
    logic       is_nop, is_act, is_rd;

    assign cmd    = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    assign is_nop = (cmd == 4'b0111);
    assign is_act = (cmd == 4'b0011);
    assign is_rd  = (cmd == 4'b0101);

    a_r1_idle_is_nop: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (is_nop && !bus_start));

    a_r2_act_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
        is_act |-> $past(req_valid && req_ready));

    a_r3_read_autoprecharge: assert property (@(posedge clk) disable iff (!rst_n)
        is_rd |-> (sd_addr[AP_BIT] && !req_ready));

    a_r4_bs_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> !bus_start);

    a_r4_bs_no_command: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |-> (is_nop && !req_ready));

    a_r6_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last |-> beat_valid);

    a_r9_known_commands: assert property (@(posedge clk) disable iff (!rst_n)
        (is_nop || is_act || is_rd));

endmodule

bind sdram_burst_rd sdram_rd_chk #(.ROW_W(ROW_W), .AP_BIT(10)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_addr(sd_addr), .bus_start(bus_start),
    .beat_valid(beat_valid), .beat_last(beat_last)
);

// File: tb/tb_sdram_burst_rd.sv
module tb_sdram_burst_rd;

    localparam int ROW_W = 12;
    localparam int COL_W = 8;
    localparam int AW    = ROW_W + COL_W + 3;
    localparam int TRCD  = 2;
    localparam int CL    = 3;
    localparam int TRP   = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_fill = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [ROW_W-1:0] sd_addr;
    logic [63:0]   sd_dq_in = '0;
    logic          bus_start, beat_valid, beat_last;
    logic [1:0]    beat_idx;
    logic [63:0]   beat_data;

    always #4 clk = ~clk;

    sdram_burst_rd #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(64),
        .T_RCD(TRCD), .CAS_LAT(CL), .T_RP(TRP)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_fill(req_fill), .req_addr(req_addr),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_addr(sd_addr), .sd_dq_in(sd_dq_in), .bus_start(bus_start),
        .beat_valid(beat_valid), .beat_idx(beat_idx), .beat_last(beat_last),
        .beat_data(beat_data)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] word(input logic [ROW_W-1:0] r, input logic [COL_W-1:0] c);
        return {8'hA5, 12'h000, r, 8'h3C, 16'h0000, c};
    endfunction

    // SDRAM model: command capture
    int cyc = 0;
    int act_cyc = -100, rd_cyc = -100;
    int n_act = 0, n_rd = 0, n_other = 0;
    bit have_rd = 1'b0;
    logic [ROW_W-1:0] act_row = '0, rd_row = '0;
    logic [COL_W-1:0] rd_col = '0;
    logic rd_ap = 1'b0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            case ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n})
                4'b0111: ;
                4'b0011: begin
                    if (have_rd)
                        chk(cyc - rd_cyc >= CL + 4 + TRP, "R8 ACTIVE too soon after READ",
                            64'(cyc - rd_cyc), 64'(CL + 4 + TRP));
                    act_row <= sd_addr;
                    act_cyc <= cyc;
                    n_act   <= n_act + 1;
                end
                4'b0101: begin
                    rd_col  <= sd_addr[COL_W-1:0];
                    rd_ap   <= sd_addr[10];
                    rd_cyc  <= cyc;
                    rd_row  <= act_row;
                    have_rd <= 1'b1;
                    n_rd    <= n_rd + 1;
                end
                default: n_other <= n_other + 1;
            endcase
        end
    end

    // SDRAM model: burst data with wraparound
    always @(negedge clk) begin
        int k;
        k = cyc - rd_cyc - CL;
        if (have_rd && k >= 0 && k < 4)
            sd_dq_in = word(rd_row, {rd_col[COL_W-1:2], rd_col[1:0] + 2'(k)});
        else
            sd_dq_in = 64'hDEAD_BEEF_0BAD_F00D;
    end

    // Output monitor
    int nb = 0, bs_cnt = 0, bs_cyc = -1, rdy_cyc = -1;
    bit prev_rdy = 1'b1;
    logic [1:0]  b_idx  [4];
    logic        b_last [4];
    logic [63:0] b_data [4];
    int          b_cyc  [4];

    always @(negedge clk) begin
        if (req_ready && !prev_rdy) rdy_cyc = cyc;
        prev_rdy = req_ready;
        if (bus_start) begin
            bs_cnt++;
            bs_cyc = cyc;
        end
        if (beat_valid) begin
            if (nb < 4) begin
                b_idx[nb]  = beat_idx;
                b_last[nb] = beat_last;
                b_data[nb] = beat_data;
                b_cyc[nb]  = cyc;
            end
            nb++;
        end
    end

    task automatic do_req(input logic fill, input logic [AW-1:0] addr);
        int a0, r0, o0, acc, start;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col, ecol;
        while (!req_ready) @(negedge clk);
        nb = 0; bs_cnt = 0;
        a0 = n_act; r0 = n_rd; o0 = n_other;
        row = addr[AW-1 -: ROW_W];
        col = addr[COL_W+2:3];
        start = int'(addr[4:3]);
        req_valid = 1'b1; req_fill = fill; req_addr = addr; acc = cyc;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R2 ready low after accept", 64'(req_ready), 64'd0);
        repeat (TRCD + CL + TRP + 8) @(negedge clk);
        chk(n_act - a0 == 1 && n_rd - r0 == 1 && n_other == o0, "R9 one ACTIVE one READ",
            64'((n_act - a0) * 16 + (n_rd - r0)), 64'h11);
        chk(act_cyc == acc + 1, "R2 ACTIVE cycle", 64'(act_cyc), 64'(acc + 1));
        chk(act_row == row, "R2 row", 64'(act_row), 64'(row));
        chk(rd_cyc - act_cyc == TRCD, "R3 tRCD spacing", 64'(rd_cyc - act_cyc), 64'(TRCD));
        chk(rd_col == col, "R3 column", 64'(rd_col), 64'(col));
        chk(rd_ap == 1'b1, "R3 auto-precharge bit", 64'(rd_ap), 64'd1);
        chk(bs_cnt == 1, "R4 bus_start count", 64'(bs_cnt), 64'd1);
        chk(bs_cyc == rd_cyc + CL, "R4 bus_start cycle", 64'(bs_cyc), 64'(rd_cyc + CL));
        chk(rdy_cyc == rd_cyc + CL + 4 + TRP, "R8 ready return",
            64'(rdy_cyc), 64'(rd_cyc + CL + 4 + TRP));
        if (fill) begin
            chk(nb == 4, "R5 fill beat count", 64'(nb), 64'd4);
            for (int i = 0; i < 4; i++) begin
                ecol = {col[COL_W-1:2], 2'(start + i)};
                chk(b_idx[i] == 2'(start + i), "R5 beat index", 64'(b_idx[i]), 64'(2'(start + i)));
                chk(b_data[i] == word(row, ecol), "R5 beat data", b_data[i], word(row, ecol));
                chk(b_cyc[i] == rd_cyc + CL + i + 1, "R5 beat timing",
                    64'(b_cyc[i]), 64'(rd_cyc + CL + i + 1));
                chk(b_last[i] == (i == 3), "R6 last flag", 64'(b_last[i]), 64'(i == 3));
            end
        end else begin
            chk(nb == 1, "R7 single beat count", 64'(nb), 64'd1);
            chk(b_idx[0] == col[1:0], "R7 single index", 64'(b_idx[0]), 64'(col[1:0]));
            chk(b_data[0] == word(row, col), "R7 single data", b_data[0], word(row, col));
            chk(b_last[0] == 1'b0, "R7 single last low", 64'(b_last[0]), 64'd0);
            chk(b_cyc[0] == rd_cyc + CL + 1, "R7 single timing",
                64'(b_cyc[0]), 64'(rd_cyc + CL + 1));
        end
    endtask

    localparam int NV = 10;
    // {fill, row, word column, byte offset}
    localparam logic [AW:0] VEC [NV] = '{
        {1'b1, 12'h123, 8'h40, 3'd0},
        {1'b1, 12'h456, 8'h41, 3'd5},
        {1'b1, 12'h789, 8'h42, 3'd0},
        {1'b1, 12'hABC, 8'h43, 3'd7},
        {1'b1, 12'hFFF, 8'hFF, 3'd1},
        {1'b0, 12'h011, 8'h10, 3'd0},
        {1'b0, 12'h022, 8'h21, 3'd3},
        {1'b0, 12'h033, 8'h32, 3'd0},
        {1'b0, 12'h044, 8'h43, 3'd6},
        {1'b0, 12'h000, 8'h00, 3'd0}
    };

    bit done = 1'b0;

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int a0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(req_ready == 1'b1, "R1 ready in reset", 64'(req_ready), 64'd1);
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R1 NOP in reset",
            64'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 64'h7);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(req_ready && !bus_start && !beat_valid && !beat_last, "R1 idle after reset",
            64'({req_ready, bus_start, beat_valid, beat_last}), 64'h8);

        for (int v = 0; v < NV; v++) begin
            do_req(VEC[v][AW], VEC[v][AW-1:0]);
        end

        // Back-to-back: valid held high through a fill, then a single read
        a0 = n_act;
        req_valid = 1'b1; req_fill = 1'b1; req_addr = {12'h5A5, 8'h13, 3'd0};
        @(negedge clk);
        req_fill = 1'b0; req_addr = {12'h6B6, 8'h22, 3'd0};
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (TRCD + CL + TRP + 8) @(negedge clk);
        chk(n_act - a0 == 2, "R2 no extra accept while busy", 64'(n_act - a0), 64'd2);
        chk(rd_row == 12'h6B6 && rd_col == 8'h22, "R3 second request address",
            64'({rd_row, rd_col}), 64'({12'h6B6, 8'h22}));

        // Reset again mid-access
        req_valid = 1'b1; req_fill = 1'b1; req_addr = {12'h101, 8'h01, 3'd0};
        @(negedge clk);
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(req_ready && !bus_start && !beat_valid, "R1 reset mid access",
            64'({req_ready, bus_start, beat_valid}), 64'h4);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        do_req(1'b1, {12'h202, 8'h02, 3'd0});

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule